// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive request lines from up to 32 peripherals and presents one interrupt line to the CPU. Each request is sampled into a register on every clock. A source counts as eligible when it is requesting, its enable bit is set and it is not already in service. The CPU line is raised while the global enable is on and at least one source is eligible.

The host learns which source to serve in two steps. It first writes the acknowledge bit of the vector register. At that clock edge the controller latches the highest-numbered eligible source as the vector and marks that source as in service. The host then reads the vector, which sits in bits 15:11 of the register. An acknowledge can arrive just after the only request was masked or dropped. Then no source is eligible, so the controller latches vector 0 and marks nothing in service, and the host only has to acknowledge it. Software ends service of a source by writing a one to that source's bit in the in-service register.

Register access uses a plain synchronous bus. A write takes effect at the rising clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low, and reads have no side effects. The bus has no handshake and never stalls, so there is no back-pressure.

Byte offsets of the registers:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | Configuration: bit 0 is the global enable | read/write |
| 0x04 | Source enable mask | read/write |
| 0x08 | In-service: write 1 to clear | read / write-1-to-clear |
| 0x0C | Sampled request levels | read only |
| 0x10 | Vector: write bit 0 = 1 to acknowledge; read returns the vector in bits 15:11 | read/write |

Top module: `vpic_top`

## Requirements
- R1: After reset, the configuration register, the mask register, the in-service register, the vector field and `irq` are all zero, so every source is masked.
- R2: Source i can win an acknowledge, or raise `irq`, only while bit i of the mask register (offset 0x04) is 1. A 0 in that bit masks the source.
- R3: Each source is level-sensitive. `src_req[i]` is registered on every clock, and the register at offset 0x0C reads back the registered levels in bits NSRC-1:0. A source whose level drops is no longer pending.
- R4: A write to offset 0x10 with data bit 0 = 1 is an acknowledge. When at least one source is eligible, the acknowledge latches the highest-numbered eligible source. That number then reads back in bits 15:11 of offset 0x10, with all other bits zero, and the source's bit in the in-service register (offset 0x08) is set.
- R5: The latched vector changes only on an acknowledge. Writes to offset 0x10 with bit 0 = 0, changes to the requests and changes to the mask all leave it unchanged.
- R6: When no source is eligible at an acknowledge, the vector becomes 0 and the in-service register does not change. This covers a request that was masked just before the acknowledge.
- R7: A write to offset 0x08 clears each in-service bit whose data bit is 1. Bits written as 0 keep their value, and only an acknowledge sets an in-service bit.
- R8: A source whose in-service bit is set is not eligible. It cannot win an acknowledge or keep `irq` high until its bit is cleared.
- R9: `irq` is high exactly while configuration bit 0 (offset 0x00) is 1 and at least one source is eligible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NSRC | Level-sensitive request from each source |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when no read is selected or the offset is unmapped |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the controller with NSRC = 8. At that size two complete sweeps are short. The first runs every one of the 256 request patterns under a full mask. The second runs every one of the 256 mask values under two fixed request patterns. For each case the bench computes the expected highest eligible source, the in-service bit and the level of `irq` both before and after the acknowledge. Every empty intersection of requests and mask exercises the error vector. Directed steps cover the reset values, the global enable gate, vector hold across other traffic, and write-one-to-clear with mixed data bits.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int VEC_LSB   = 11;
  localparam int VEC_FIELD = 5;

  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_INSVC = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_VEC   = 5'h10;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE
  } bus_op_e;
endpackage

// File: rtl/vpic_sample.sv
module vpic_sample #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  output logic [NSRC-1:0] req_q
);
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q[gi] <= 1'b0;
        else        req_q[gi] <= req_in[gi];
      end
    end
  endgenerate
endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int NSRC  = 32,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  elig,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   req_q,
  output logic [NSRC-1:0]   elig,
  input  logic              win_any,
  input  logic [IDX_W-1:0]  win_idx,
  output logic              irq
);
  logic              cfg_en_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   insvc_q;
  logic [IDX_W-1:0]  vec_q;
  logic [NSRC-1:0]   win_oh;
  logic [VEC_FIELD-1:0] vec_ext;
  bus_op_e           op;
  logic              ack;
  logic              eoi;

  always_comb begin
    if (!bus_sel)    op = OP_NONE;
    else if (bus_wr) op = OP_WRITE;
    else             op = OP_READ;
  end

  assign ack = (op == OP_WRITE) && (bus_addr == OFS_VEC) && bus_wdata[0];
  assign eoi = (op == OP_WRITE) && (bus_addr == OFS_INSVC);

  assign elig = req_q & mask_q & ~insvc_q;
  assign irq  = cfg_en_q & win_any;

  always_comb begin
    win_oh = '0;
    win_oh[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q <= 1'b0;
      mask_q   <= '0;
      insvc_q  <= '0;
      vec_q    <= '0;
    end else begin
      if (op == OP_WRITE && bus_addr == OFS_CFG)  cfg_en_q <= bus_wdata[0];
      if (op == OP_WRITE && bus_addr == OFS_MASK) mask_q   <= bus_wdata[NSRC-1:0];
      if (eoi) insvc_q <= insvc_q & ~bus_wdata[NSRC-1:0];
      if (ack) begin
        if (win_any) begin
          vec_q   <= win_idx;
          insvc_q <= insvc_q | win_oh;
        end else begin
          vec_q   <= '0;
        end
      end
    end
  end

  assign vec_ext = VEC_FIELD'(vec_q);

  always_comb begin
    bus_rdata = '0;
    if (op == OP_READ) begin
      case (bus_addr)
        OFS_CFG:   bus_rdata = {{(DATA_W-1){1'b0}}, cfg_en_q};
        OFS_MASK:  bus_rdata = DATA_W'(mask_q);
        OFS_INSVC: bus_rdata = DATA_W'(insvc_q);
        OFS_RAW:   bus_rdata = DATA_W'(req_q);
        OFS_VEC:   bus_rdata = DATA_W'({vec_ext, {VEC_LSB{1'b0}}});
        default:   bus_rdata = '0;
      endcase
    end
  end

  a_r2_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> mask_q[win_idx]);

  a_r8_busy_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> !insvc_q[win_idx]);

  a_r4_ack_marks_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && win_any) |=> $countones(insvc_q) == $past($countones(insvc_q)) + 1);

  a_r6_err_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !win_any) |=> (vec_q == '0) && $stable(insvc_q));

  a_r5_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vec_q));

  a_r7_no_set_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (insvc_q & ~$past(insvc_q)) == '0);
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  req_q;
  logic [NSRC-1:0]  elig;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;

  vpic_sample #(.NSRC(NSRC)) u_sample (
    .clk(clk), .rst_n(rst_n), .req_in(src_req), .req_q(req_q)
  );

  vpic_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
    .elig(elig), .any(win_any), .idx(win_idx)
  );

  vpic_regs #(.NSRC(NSRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_q(req_q), .elig(elig),
    .win_any(win_any), .win_idx(win_idx), .irq(irq)
  );

  a_r9_irq_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (req_q != '0));
endmodule

// File: tb/sim_vpic_top.sv
module sim_vpic_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vpic_top #(.NSRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int top_bit(input logic [N-1:0] v);
    int r = -1;
    for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic run_case(input logic [N-1:0] p, input logic [N-1:0] m);
    logic [31:0] d;
    logic [N-1:0] oh;
    int w;
    @(negedge clk);
    src_req = p;
    wr(5'h04, 32'(m));
    w = top_bit(p & m);
    oh = (w < 0) ? '0 : (N'(1) << w);
    #1 chk("R9 irq before ack", 32'(irq), 32'((p & m) != '0));
    wr(5'h10, 32'h1);
    rd(5'h10, d);
    chk("R4/R6 vector", d, (w < 0) ? 32'h0 : (32'(w) << 11));
    rd(5'h08, d);
    chk("R4 in-service bit", d, 32'(oh));
    #1 chk("R8 irq after ack", 32'(irq), 32'((p & m & ~oh) != '0));
    wr(5'h08, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, d); chk("R1 cfg reset", d, 32'h0);
    rd(5'h04, d); chk("R1 mask reset", d, 32'h0);
    rd(5'h08, d); chk("R1 insvc reset", d, 32'h0);
    rd(5'h10, d); chk("R1 vector reset", d, 32'h0);
    #1 chk("R1 irq reset", 32'(irq), 32'h0);

    // R2: all masked after reset, request gives no irq even when enabled
    wr(5'h00, 32'h1);
    @(negedge clk); src_req = 8'hFF;
    @(negedge clk); #1 chk("R2 masked sources no irq", 32'(irq), 32'h0);
    rd(5'h0C, d); chk("R3 raw levels", d, 32'h0000_00FF);

    // R9: global enable gates irq
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0000_0010);
    #1 chk("R9 disabled no irq", 32'(irq), 32'h0);
    wr(5'h00, 32'h1);
    #1 chk("R9 enabled irq", 32'(irq), 32'h1);

    // R3: dropping the level removes the request
    @(negedge clk); src_req = 8'h00;
    @(negedge clk); #1 chk("R3 level drop clears irq", 32'(irq), 32'h0);
    rd(5'h0C, d); chk("R3 raw after drop", d, 32'h0);

    // R5: vector holds across other traffic
    @(negedge clk); src_req = 8'h30;
    wr(5'h04, 32'h0000_00FF);
    wr(5'h10, 32'h1);
    rd(5'h10, v0); chk("R4 vector 5", v0, 32'h5 << 11);
    wr(5'h10, 32'h0);
    rd(5'h10, d); chk("R5 hold on bit0=0 write", d, v0);
    @(negedge clk); src_req = 8'h81;
    wr(5'h04, 32'h0000_0003);
    rd(5'h10, d); chk("R5 hold on mask/request change", d, v0);

    // R7: write-one-to-clear with mixed bits
    wr(5'h04, 32'h0000_00FF);
    wr(5'h10, 32'h1);
    rd(5'h08, d); chk("R7 two in service", d, 32'h0000_00A0);
    wr(5'h08, 32'h0000_005F);
    rd(5'h08, d); chk("R7 zero bits keep", d, 32'h0000_00A0);
    wr(5'h08, 32'h0000_0080);
    rd(5'h08, d); chk("R7 one bit clears", d, 32'h0000_0020);
    wr(5'h08, 32'hFFFF_FFFF);

    // R6: request masked right before ack
    @(negedge clk); src_req = 8'h04;
    wr(5'h04, 32'h0000_0004);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'h1);
    rd(5'h10, d); chk("R6 race error vector", d, 32'h0);
    rd(5'h08, d); chk("R6 nothing in service", d, 32'h0);

    // Sweeps
    for (int p = 0; p < 256; p++) run_case(8'(p), 8'hFF);
    for (int m = 0; m < 256; m++) run_case(8'hA5, 8'(m));
    for (int m = 0; m < 256; m++) run_case(8'h5A, 8'(m));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule